// File: doc/BRIEF.md
# Handshaked Byte-Serial Command Engine

This block is the device side of a byte-at-a-time command link. A host pushes a command code and its argument bytes through a shift-register data port. The host then pulls back the response bytes through the same port. Every byte is paced by two active-low handshake bits held in an 8-bit port register: the host drives the request bit, and the engine answers on the acknowledge bit. A byte moves only when the host writes a new value to the port register.

The engine runs through three phases: idle, command and response. In the idle phase the received byte selects a command, and a built-in length table gives the number of argument bytes and response bytes. Either length may be marked variable. A variable argument count arrives as the first argument byte. A variable response size is sent to the host ahead of the response bytes. When all arguments are held in a 32-byte buffer, the engine pulses a dispatch strobe to an external executor. The executor fills a 32-byte response buffer and reports whether it recognised the command. The engine then streams the response and goes back to idle. The shift register, the executor and the host bus are modelled here as plain ports.

Top module: `hsbs_cmd_engine`

## Requirements
- R1: After reset `port_q` is 8'h18 (request bit 4 and acknowledge bit 3 both high), `phase` is 0 (idle), and `sr_irq`, `proto_err` and `disp_stb` are low.
- R2: A port write whose value equals `port_q` has no effect. A changed write whose bits [4:3] are 2'b11 is stored unchanged and starts no transfer.
- R3: A changed write with bit 4 high and bit 3 low (release) is stored with bit 3 forced high, and no byte is transferred.
- R4: A changed write with bit 4 low and bit 3 high (request) is stored with bit 3 forced low. One byte is then handled for the current phase, and each byte moved in either direction makes `sr_irq` pulse for one cycle, the cycle after the write.
- R5: A changed write with bits [4:3] both low is stored and makes `proto_err` pulse, and the phase does not change.
- R6: In idle (`phase`=0) with `sr_host_to_dev` high, the received byte becomes the command code and `phase` becomes 1 (command). The length table is: 8'h10 args 1 / rsp 0; 8'h20 args variable / rsp 0; 8'h28 args 0 / rsp variable; 8'h30 args 4 / rsp 0; 8'h38 args 0 / rsp 4; 8'h40 args 2 / rsp 3; 8'hF0-8'hFF args 0 / rsp variable; any other code args 0 / rsp 2.
- R7: In the command phase, argument bytes are stored in arrival order and can be read back through `arg_rd_idx`. When the stored count reaches the argument length, `disp_stb` pulses for one cycle with `disp_cmd` and `disp_argc`, and `phase` becomes 2 (response).
- R8: For a variable argument length, the first byte of the command phase is the argument count and is not stored.
- R9: A zero argument length dispatches on the same request that carried the command code. A zero fixed response length returns to idle on that same request.
- R10: In the response phase with `sr_host_to_dev` low, a fixed-length response sends response-buffer bytes 0, 1, … on `sr_tx_byte`. The engine returns to idle after the last byte.
- R11: For a variable response length of a recognised command, the first byte sent is `exec_rsp_size`, limited to 32. That many buffer bytes follow.
- R12: When `exec_known` is low at dispatch, a fixed response length sends that many 8'h00 bytes. A variable one sends the single size byte 8'h00.
- R13: A request whose shift direction does not match the phase (host-to-device needed in idle and command, device-to-host in response) clears the acknowledge bit and makes `proto_err` pulse. It moves no byte and leaves the phase and counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_we | input | 1 | Host write strobe for the handshake port register |
| port_wdata | input | 8 | Value written by the host (bit 4 request, bit 3 acknowledge) |
| port_q | output | 8 | Current port register, acknowledge bit as driven by the engine |
| sr_host_to_dev | input | 1 | Shift direction: 1 host-to-device, 0 device-to-host |
| sr_rx_byte | input | 8 | Byte shifted in by the host |
| sr_tx_byte | output | 8 | Last byte loaded for the host to shift out |
| sr_irq | output | 1 | One-cycle pulse per transferred byte |
| proto_err | output | 1 | One-cycle pulse on an invalid handshake or wrong direction |
| phase | output | 2 | 0 idle, 1 command, 2 response |
| disp_stb | output | 1 | One-cycle dispatch pulse to the executor |
| disp_cmd | output | 8 | Current command code |
| disp_argc | output | 6 | Number of stored argument bytes |
| arg_rd_idx | input | 5 | Argument buffer read index |
| arg_rd_byte | output | 8 | Argument byte at `arg_rd_idx` |
| exec_known | input | 1 | Executor recognises the command (sampled at dispatch) |
| exec_rsp_size | input | 8 | Executor response size for variable-length responses |
| exec_wr | input | 1 | Executor response-buffer write enable |
| exec_wr_idx | input | 5 | Response-buffer write index |
| exec_wr_byte | input | 8 | Response-buffer write data |

## Verification
The command stream covers fixed argument counts, a variable count taken from the first argument, zero-argument commands, and fixed, variable, clamped and unrecognised responses. These separate dispatch timing from response sizing and from zero filling. Unchanged writes, writes that change only other bits, and the both-low handshake check that only a real handshake transition moves data. Requests with the wrong direction in each phase show that an error clears the acknowledge bit but moves nothing. A behavioural reference model, built on queues, predicts every output on every clock.

// File: rtl/hsbs_pkg.sv
package hsbs_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_RSP  = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      HS_QUIET   = 2'd0,
      HS_RELEASE = 2'd1,
      HS_REQUEST = 2'd2,
      HS_BAD     = 2'd3
   } hs_kind_e;

   typedef struct packed {
      logic       arg_var;
      logic [7:0] arg_len;
      logic       rsp_var;
      logic [7:0] rsp_len;
   } len_entry_t;

   function automatic len_entry_t len_lookup(input logic [7:0] code);
      len_entry_t e;
      e = '{arg_var: 1'b0, arg_len: 8'd0, rsp_var: 1'b0, rsp_len: 8'd2};
      if (code[7:4] == 4'hF) begin
         e.rsp_var = 1'b1;
         e.rsp_len = 8'd0;
      end else begin
         unique case (code)
            8'h10: begin e.arg_len = 8'd1; e.rsp_len = 8'd0; end
            8'h20: begin e.arg_var = 1'b1; e.rsp_len = 8'd0; end
            8'h28: begin e.rsp_var = 1'b1; e.rsp_len = 8'd0; end
            8'h30: begin e.arg_len = 8'd4; e.rsp_len = 8'd0; end
            8'h38: begin e.rsp_len = 8'd4; end
            8'h40: begin e.arg_len = 8'd2; e.rsp_len = 8'd3; end
            default: ;
         endcase
      end
      return e;
   endfunction

endpackage

// File: rtl/hsbs_hs_decode.sv
module hsbs_hs_decode
   import hsbs_pkg::*;
#(
   parameter int PORT_W  = 8,
   parameter int REQ_BIT = 4,
   parameter int ACK_BIT = 3
) (
   input  logic              port_we,
   input  logic [PORT_W-1:0] port_wdata,
   input  logic [PORT_W-1:0] port_cur,
   output logic              changed,
   output hs_kind_e          kind
);

   if (REQ_BIT >= PORT_W || ACK_BIT >= PORT_W || REQ_BIT == ACK_BIT) begin : g_bad_bits
      $error("hsbs_hs_decode: handshake bit positions invalid");
   end

   assign changed = port_we && (port_wdata != port_cur);

   always_comb begin
      unique case ({port_wdata[REQ_BIT], port_wdata[ACK_BIT]})
         2'b11:   kind = HS_QUIET;
         2'b10:   kind = HS_RELEASE;
         2'b01:   kind = HS_REQUEST;
         default: kind = HS_BAD;
      endcase
   end

endmodule

// File: rtl/hsbs_byte_buf.sv
module hsbs_byte_buf #(
   parameter int DEPTH       = 32,
   parameter int DATA_W      = 8,
   parameter bit RESET_CLEAR = 1'b1,
   localparam int IDX_W      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("hsbs_byte_buf: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      if (RESET_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mem[i] <= '0;
            else if (we && widx == IDX_W'(i))  mem[i] <= wdata;
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(i)) mem[i] <= wdata;
         end
      end
   end

   assign rdata = mem[ridx];

endmodule

// File: rtl/hsbs_cmd_engine.sv
module hsbs_cmd_engine
   import hsbs_pkg::*;
#(
   parameter int BUF_DEPTH = 32,
   parameter int REQ_BIT   = 4,
   parameter int ACK_BIT   = 3,
   localparam int IDX_W    = $clog2(BUF_DEPTH),
   localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             port_we,
   input  logic [7:0]       port_wdata,
   output logic [7:0]       port_q,
   input  logic             sr_host_to_dev,
   input  logic [7:0]       sr_rx_byte,
   output logic [7:0]       sr_tx_byte,
   output logic             sr_irq,
   output logic             proto_err,
   output logic [1:0]       phase,
   output logic             disp_stb,
   output logic [7:0]       disp_cmd,
   output logic [CNT_W-1:0] disp_argc,
   input  logic [IDX_W-1:0] arg_rd_idx,
   output logic [7:0]       arg_rd_byte,
   input  logic             exec_known,
   input  logic [7:0]       exec_rsp_size,
   input  logic             exec_wr,
   input  logic [IDX_W-1:0] exec_wr_idx,
   input  logic [7:0]       exec_wr_byte
);

   if (BUF_DEPTH > 128) begin : g_bad_cnt
      $error("hsbs_cmd_engine: BUF_DEPTH must fit an 8-bit length");
   end

   localparam logic [7:0]       PORT_RST = 8'((1 << REQ_BIT) | (1 << ACK_BIT));
   localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(BUF_DEPTH);

   phase_e           phase_q, phase_d;
   logic [7:0]       port_d, cmd_q, cmd_d, alen_q, alen_d, tx_q, tx_d;
   logic             avar_q, avar_d, rvar_q, rvar_d, known_q, known_d;
   logic [CNT_W-1:0] apos_q, apos_d, rpos_q, rpos_d, rcnt_q, rcnt_d;
   logic             irq_d, err_d, disp_d, arg_we, dir_ok;
   logic [7:0]       rsp_rdata;
   logic             hs_chg;
   hs_kind_e         hs_kind;
   len_entry_t       ent;

   hsbs_hs_decode #(.PORT_W(8), .REQ_BIT(REQ_BIT), .ACK_BIT(ACK_BIT)) hs_i (
      .port_we(port_we), .port_wdata(port_wdata), .port_cur(port_q),
      .changed(hs_chg), .kind(hs_kind)
   );

   hsbs_byte_buf #(.DEPTH(BUF_DEPTH), .DATA_W(8), .RESET_CLEAR(1'b0)) arg_buf_i (
      .clk(clk), .rst_n(rst_n), .we(arg_we), .widx(apos_q[IDX_W-1:0]),
      .wdata(sr_rx_byte), .ridx(arg_rd_idx), .rdata(arg_rd_byte)
   );

   hsbs_byte_buf #(.DEPTH(BUF_DEPTH), .DATA_W(8), .RESET_CLEAR(1'b1)) rsp_buf_i (
      .clk(clk), .rst_n(rst_n), .we(exec_wr), .widx(exec_wr_idx),
      .wdata(exec_wr_byte), .ridx(rpos_q[IDX_W-1:0]), .rdata(rsp_rdata)
   );

   assign ent = len_lookup(sr_rx_byte);

   always_comb begin
      port_d  = port_q;   phase_d = phase_q;  cmd_d   = cmd_q;
      avar_d  = avar_q;   alen_d  = alen_q;   rvar_d  = rvar_q;
      rcnt_d  = rcnt_q;   apos_d  = apos_q;   rpos_d  = rpos_q;
      known_d = known_q;  tx_d    = tx_q;
      irq_d   = 1'b0;     err_d   = 1'b0;     disp_d  = 1'b0;
      arg_we  = 1'b0;
      dir_ok  = (phase_q == PH_RSP) ? !sr_host_to_dev : sr_host_to_dev;
      if (hs_chg) begin
         port_d = port_wdata;
         unique case (hs_kind)
            HS_RELEASE: port_d[ACK_BIT] = 1'b1;
            HS_BAD:     err_d = 1'b1;
            HS_REQUEST: begin
               port_d[ACK_BIT] = 1'b0;
               if (!dir_ok) begin
                  err_d = 1'b1;
               end else begin
                  irq_d = 1'b1;
                  unique case (phase_q)
                     PH_IDLE: begin
                        cmd_d   = sr_rx_byte;
                        avar_d  = ent.arg_var;
                        alen_d  = ent.arg_len;
                        rvar_d  = ent.rsp_var;
                        rcnt_d  = CNT_W'(ent.rsp_len);
                        apos_d  = '0;
                        rpos_d  = '0;
                        phase_d = PH_CMD;
                     end
                     PH_CMD: begin
                        if (avar_q) begin
                           alen_d = sr_rx_byte;
                           avar_d = 1'b0;
                        end else if (apos_q < DEPTH_C) begin
                           arg_we = 1'b1;
                           apos_d = apos_q + 1'b1;
                        end
                     end
                     default: begin
                        if (rvar_q) begin
                           tx_d   = 8'(rcnt_q);
                           rvar_d = 1'b0;
                        end else if (rpos_q < rcnt_q) begin
                           tx_d   = known_q ? rsp_rdata : 8'h00;
                           rpos_d = rpos_q + 1'b1;
                        end
                     end
                  endcase
                  if (phase_d == PH_CMD && !avar_d && alen_d == 8'(apos_d)) begin
                     disp_d  = 1'b1;
                     phase_d = PH_RSP;
                     known_d = exec_known;
                     if (rvar_d) begin
                        if (!exec_known)                 rcnt_d = '0;
                        else if (exec_rsp_size > 8'(DEPTH_C)) rcnt_d = DEPTH_C;
                        else                             rcnt_d = CNT_W'(exec_rsp_size);
                     end
                  end
                  if (phase_d == PH_RSP && !rvar_d && rcnt_d == rpos_d) phase_d = PH_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q  <= PORT_RST;  phase_q <= PH_IDLE;  cmd_q   <= '0;
         avar_q  <= 1'b0;      alen_q  <= '0;       rvar_q  <= 1'b0;
         rcnt_q  <= '0;        apos_q  <= '0;       rpos_q  <= '0;
         known_q <= 1'b0;      tx_q    <= '0;
         sr_irq  <= 1'b0;      proto_err <= 1'b0;   disp_stb <= 1'b0;
      end else begin
         port_q  <= port_d;    phase_q <= phase_d;  cmd_q   <= cmd_d;
         avar_q  <= avar_d;    alen_q  <= alen_d;   rvar_q  <= rvar_d;
         rcnt_q  <= rcnt_d;    apos_q  <= apos_d;   rpos_q  <= rpos_d;
         known_q <= known_d;   tx_q    <= tx_d;
         sr_irq  <= irq_d;     proto_err <= err_d;  disp_stb <= disp_d;
      end
   end

   assign sr_tx_byte = tx_q;
   assign phase      = phase_q;
   assign disp_cmd   = cmd_q;
   assign disp_argc  = apos_q;

   // R2
   no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_we || port_wdata == port_q) |=> ($stable(port_q) && !sr_irq && !proto_err));

   // R3
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_we && port_wdata != port_q && port_wdata[REQ_BIT] && !port_wdata[ACK_BIT])
      |=> (port_q[ACK_BIT] && !sr_irq));

   // R4
   ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_we && port_wdata != port_q && !port_wdata[REQ_BIT] && port_wdata[ACK_BIT])
      |=> !port_q[ACK_BIT]);

   // R13
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> ($stable(phase) && $stable(disp_argc) && !sr_irq));

   // R7
   disp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stb |-> (phase != PH_CMD && sr_irq));

   // R7
   argc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_argc <= DEPTH_C);

endmodule

// File: tb/hsbs_cmd_engine_tb.sv
module hsbs_cmd_engine_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_we = 1'b0;
   logic [7:0] port_wdata = 8'h18;
   logic [7:0] port_q;
   logic       sr_host_to_dev = 1'b1;
   logic [7:0] sr_rx_byte = 8'h00;
   logic [7:0] sr_tx_byte;
   logic       sr_irq, proto_err, disp_stb;
   logic [1:0] phase;
   logic [7:0] disp_cmd;
   logic [5:0] disp_argc;
   logic [4:0] arg_rd_idx = '0;
   logic [7:0] arg_rd_byte;
   logic       exec_known = 1'b1;
   logic [7:0] exec_rsp_size = 8'd0;
   logic       exec_wr = 1'b0;
   logic [4:0] exec_wr_idx = '0;
   logic [7:0] exec_wr_byte = '0;

   always #5 clk = ~clk;

   hsbs_cmd_engine dut_i (
      .clk(clk), .rst_n(rst_n), .port_we(port_we), .port_wdata(port_wdata), .port_q(port_q),
      .sr_host_to_dev(sr_host_to_dev), .sr_rx_byte(sr_rx_byte), .sr_tx_byte(sr_tx_byte),
      .sr_irq(sr_irq), .proto_err(proto_err), .phase(phase), .disp_stb(disp_stb),
      .disp_cmd(disp_cmd), .disp_argc(disp_argc), .arg_rd_idx(arg_rd_idx),
      .arg_rd_byte(arg_rd_byte), .exec_known(exec_known), .exec_rsp_size(exec_rsp_size),
      .exec_wr(exec_wr), .exec_wr_idx(exec_wr_idx), .exec_wr_byte(exec_wr_byte)
   );

   int nchk = 0, nfail = 0;
   string tag = "R1";

   // reference model state
   int m_port = 8'h18, m_phase = 0, m_cmd = 0, m_avar = 0, m_alen = 0;
   int m_rvar = 0, m_rcnt = 0, m_rpos = 0, m_known = 0, m_tx = 0;
   int e_irq = 0, e_err = 0, e_disp = 0;
   int m_args[$];
   int m_rsp[32];

   task automatic check(string req, int act, int exp, string what);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // length table from R6
   task automatic table_of(input int code, output int av, output int al, output int rv, output int rl);
      av = 0; al = 0; rv = 0; rl = 2;
      if (code >= 8'hF0) begin rv = 1; rl = 0; end
      else if (code == 8'h10) begin al = 1; rl = 0; end
      else if (code == 8'h20) begin av = 1; rl = 0; end
      else if (code == 8'h28) begin rv = 1; rl = 0; end
      else if (code == 8'h30) begin al = 4; rl = 0; end
      else if (code == 8'h38) begin rl = 4; end
      else if (code == 8'h40) begin al = 2; rl = 3; end
   endtask

   task automatic model(input bit we, input int wd, input bit dir, input int rx);
      e_irq = 0; e_err = 0; e_disp = 0;
      if (we && wd != m_port) begin
         m_port = wd;
         if (wd[4] && !wd[3]) m_port = m_port | 8'h08;
         else if (!wd[4] && !wd[3]) e_err = 1;
         else if (!wd[4] && wd[3]) begin
            m_port = m_port & 8'hF7;
            if ((m_phase == 2) == dir) e_err = 1;
            else begin
               e_irq = 1;
               if (m_phase == 0) begin
                  m_cmd = rx;
                  table_of(rx, m_avar, m_alen, m_rvar, m_rcnt);
                  m_args.delete();
                  m_rpos = 0;
                  m_phase = 1;
               end else if (m_phase == 1) begin
                  if (m_avar) begin m_alen = rx; m_avar = 0; end
                  else if (m_args.size() < 32) m_args.push_back(rx);
               end else begin
                  if (m_rvar) begin m_tx = m_rcnt; m_rvar = 0; end
                  else if (m_rpos < m_rcnt) begin
                     m_tx = m_known ? m_rsp[m_rpos] : 0;
                     m_rpos++;
                  end
               end
               if (m_phase == 1 && !m_avar && m_alen == m_args.size()) begin
                  e_disp = 1; m_phase = 2; m_known = exec_known;
                  if (m_rvar) m_rcnt = !exec_known ? 0 : (exec_rsp_size > 32 ? 32 : int'(exec_rsp_size));
               end
               if (m_phase == 2 && !m_rvar && m_rcnt == m_rpos) m_phase = 0;
            end
         end
      end
   endtask

   // one clock: drive at negedge, model, compare at following negedge
   task automatic step(input bit we, input int wd, input bit dir, input int rx);
      port_we = we; port_wdata = 8'(wd); sr_host_to_dev = dir; sr_rx_byte = 8'(rx);
      model(we, wd, dir, rx);
      @(posedge clk);
      @(negedge clk);
      port_we = 1'b0; exec_wr = 1'b0;
      check(tag, port_q, m_port, "port_q");
      check(tag, phase, m_phase, "phase");
      check(tag, sr_irq, e_irq, "sr_irq");
      check(tag, proto_err, e_err, "proto_err");
      check(tag, disp_stb, e_disp, "disp_stb");
      check(tag, sr_tx_byte, m_tx, "sr_tx_byte");
      if (e_disp) begin
         check(tag, disp_cmd, m_cmd, "disp_cmd");
         check(tag, disp_argc, m_args.size(), "disp_argc");
      end
   endtask

   task automatic xfer(input bit dir, input int rx);
      step(1'b1, 8'h08, dir, rx);
      step(1'b1, 8'h10, dir, rx);
   endtask

   task automatic check_args();
      foreach (m_args[i]) begin
         arg_rd_idx = 5'(i);
         #1;
         check(tag, arg_rd_byte, m_args[i], "arg_rd_byte");
      end
   endtask

   bit done = 1'b0;

   initial begin
      #(200000 * 10);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R1 reset state
      check("R1", port_q, 8'h18, "port_q");
      check("R1", phase, 0, "phase");
      check("R1", sr_irq, 0, "sr_irq");
      check("R1", proto_err, 0, "proto_err");
      check("R1", disp_stb, 0, "disp_stb");
      rst_n = 1'b1;
      tag = "R1";
      step(1'b0, 8'h18, 1'b1, 0);

      // executor response buffer
      for (int i = 0; i < 32; i++) begin
         exec_wr = 1'b1; exec_wr_idx = 5'(i); exec_wr_byte = 8'(8'hA0 + i);
         m_rsp[i] = 8'hA0 + i;
         step(1'b0, 8'h18, 1'b1, 0);
      end

      // R2 unchanged write, then change of other bits only
      tag = "R2";
      step(1'b1, 8'h18, 1'b1, 8'h30);
      step(1'b1, 8'h5A, 1'b1, 8'h30);
      step(1'b1, 8'h18, 1'b1, 8'h30);

      // R5 both lines low
      tag = "R5";
      step(1'b1, 8'h00, 1'b1, 8'h30);
      step(1'b1, 8'h18, 1'b1, 8'h30);

      // R13 wrong direction in idle
      tag = "R13";
      xfer(1'b0, 8'h30);

      // R7 fixed 4 args, R9 zero response returns to idle
      tag = "R7";
      xfer(1'b1, 8'h30);
      xfer(1'b1, 8'h11); xfer(1'b1, 8'h22);
      tag = "R13";
      xfer(1'b0, 8'h99);
      tag = "R7";
      xfer(1'b1, 8'h33); xfer(1'b1, 8'h44);
      check_args();

      // R10 fixed response with a direction error inside
      tag = "R10";
      xfer(1'b1, 8'h40); xfer(1'b1, 8'h5C); xfer(1'b1, 8'h6D);
      check_args();
      xfer(1'b0, 0);
      tag = "R13";
      xfer(1'b1, 8'h77);
      tag = "R10";
      xfer(1'b0, 0); xfer(1'b0, 0);

      // R8 variable arg count
      tag = "R8";
      xfer(1'b1, 8'h20); xfer(1'b1, 8'd3);
      xfer(1'b1, 8'hC1); xfer(1'b1, 8'hC2); xfer(1'b1, 8'hC3);
      check_args();

      // R9 zero-length args dispatch with the code byte
      tag = "R9";
      xfer(1'b1, 8'h38);
      for (int i = 0; i < 4; i++) xfer(1'b0, 0);

      // R11 variable response
      tag = "R11";
      exec_rsp_size = 8'd5;
      xfer(1'b1, 8'h28);
      for (int i = 0; i < 6; i++) xfer(1'b0, 0);
      exec_rsp_size = 8'd40;
      xfer(1'b1, 8'hF7);
      for (int i = 0; i < 33; i++) xfer(1'b0, 0);

      // R12 unknown command
      tag = "R12";
      exec_known = 1'b0;
      exec_rsp_size = 8'd6;
      xfer(1'b1, 8'h55);
      xfer(1'b0, 0); xfer(1'b0, 0);
      xfer(1'b1, 8'hF3);
      xfer(1'b0, 0);
      exec_known = 1'b1;

      // R4 plain one-arg command, R6 phase flow
      tag = "R6";
      xfer(1'b1, 8'h10);
      tag = "R4";
      xfer(1'b1, 8'hEE);
      step(1'b0, 8'h18, 1'b1, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule